// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract Unit

This is a purely combinational arithmetic slice for an 8-bit accumulator datapath. It takes the accumulator value, an operand, an incoming carry, a decimal-mode flag and an add/subtract select. It returns the 8-bit result and four status flags: negative, overflow, zero and carry.

In binary mode it behaves as an ordinary add-with-carry or subtract-with-borrow. For subtraction, the carry input set to 1 means "no borrow".

In decimal mode each byte holds two packed BCD digits, and the unit applies nibble corrections. The status flags reproduce the behaviour of the classic NMOS core, not flags derived from the corrected result:
- On decimal addition, zero comes from the plain binary sum.
- On decimal addition, negative and overflow come from the high digit before its final +6 correction.
- On decimal subtraction, every flag comes from the plain binary difference.

Register storage, opcode decode and the other ALU operations live elsewhere.

Top module: `bcd_addsub_unit`

## Requirements
- R1: Binary add (decimal_i=0, sub_i=0): result_o is (acc_i + opnd_i + carry_i) mod 256, and carry_o is 1 exactly when that sum exceeds 255.
- R2: Binary add: ovf_o is 1 when acc_i[7] equals opnd_i[7] and result_o[7] differs from acc_i[7]. neg_o equals result_o[7]. zero_o is 1 when result_o is 0.
- R3: Binary subtract (decimal_i=0, sub_i=1): result_o is (acc_i - opnd_i - (1 - carry_i)) mod 256, and carry_o is 1 exactly when that difference is not negative.
- R4: Binary subtract: ovf_o is 1 when acc_i[7] differs from opnd_i[7] and result_o[7] differs from acc_i[7]. neg_o equals result_o[7]. zero_o is 1 when result_o is 0.
- R5: Decimal add (decimal_i=1, sub_i=0): the low digit is L = acc_i[3:0] + opnd_i[3:0] + carry_i, plus 6 when L exceeds 9. result_o[3:0] is the low 4 bits of that value, and a corrected L above 15 carries 1 into the high digit.
- R6: Decimal add: zero_o is 1 exactly when (acc_i + opnd_i + carry_i) mod 256 is 0. The corrected result does not affect it.
- R7: Decimal add: let H be acc_i[7:4] + opnd_i[7:4] plus the low-digit carry, before any high correction. neg_o is H bit 3. ovf_o is 1 when H bit 3 differs from acc_i[7] and acc_i[7] equals opnd_i[7].
- R8: Decimal add: when H exceeds 9, 6 is added to it. carry_o is 1 when the corrected H exceeds 15, and result_o[7:4] is its low 4 bits.
- R9: Decimal subtract (decimal_i=1, sub_i=1): the low digit is acc_i[3:0] - opnd_i[3:0] - (1 - carry_i). When it goes negative, 6 is subtracted from it and 1 from the high digit acc_i[7:4] - opnd_i[7:4]. When the high digit goes negative, 6 is subtracted from it. result_o is the two digits' low 4 bits.
- R10: Decimal subtract: carry_o, ovf_o, neg_o and zero_o equal exactly the binary-subtract flags of R3 and R4 for the same inputs.
- R11: Decimal add with both operands valid BCD (each digit 0..9): result_o is the BCD encoding of (value(acc) + value(opnd) + carry_i) mod 100, and carry_o is 1 when that total is 100 or more.
- R12: Decimal subtract with both operands valid BCD: result_o is the BCD encoding of (value(acc) - value(opnd) - (1 - carry_i)) mod 100, and carry_o is 1 when the difference is not negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand value |
| carry_i | input | 1 | Carry in (for subtract, 1 means no borrow) |
| decimal_i | input | 1 | 1 selects packed-BCD arithmetic |
| sub_i | input | 1 | 0 selects add, 1 selects subtract |
| result_o | output | 8 | Arithmetic result |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry out (for subtract, 1 means no borrow) |

## Verification
All 2^19 combinations of the inputs are applied. Every output is compared against an integer model that restates the rules, including the non-BCD operand codes 0xA..0xF.

The bench targets several corner cases:
- Decimal additions whose corrected byte is zero but whose binary sum is not, such as 0x99+0x01. A design that derived zero from the corrected result would raise zero_o there.
- Sums where the raw high digit is 8..15. A design that took neg_o or ovf_o from the corrected digit would flip them.
- Decimal subtractions that borrow out of both digits. A design that ignored the low borrow into the high digit, or skipped the -6 step, would give the wrong digits.
- Cases where the carry input is 0. A design that inverted the borrow sense would fail every one of them.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    word_t res;
    logic  n;
    logic  v;
    logic  z;
    logic  c;
  } alu_flags_t;

  // binary add with carry
  function automatic alu_flags_t bin_add(word_t a, word_t b, logic ci);
    alu_flags_t r;
    logic [DATA_W:0] s;
    s     = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
    r.res = s[DATA_W-1:0];
    r.c   = s[DATA_W];
    r.n   = s[MSB];
    r.z   = (s[DATA_W-1:0] == '0);
    r.v   = (a[MSB] == b[MSB]) && (s[MSB] != a[MSB]);
    return r;
  endfunction

  // binary subtract, ci = 1 means no borrow
  function automatic alu_flags_t bin_sub(word_t a, word_t b, logic ci);
    alu_flags_t r;
    logic [DATA_W:0] s;
    s     = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, ~ci};
    r.res = s[DATA_W-1:0];
    r.c   = ~s[DATA_W];
    r.n   = s[MSB];
    r.z   = (s[DATA_W-1:0] == '0);
    r.v   = (a[MSB] != b[MSB]) && (s[MSB] != a[MSB]);
    return r;
  endfunction

  // value of a packed two-digit BCD byte
  function automatic int bcd_val(word_t w);
    return int'(w[DATA_W-1:NIB_W]) * 10 + int'(w[NIB_W-1:0]);
  endfunction

  function automatic logic is_bcd(word_t w);
    return (w[DATA_W-1:NIB_W] <= 4'd9) && (w[NIB_W-1:0] <= 4'd9);
  endfunction
endpackage

// File: rtl/bin_addsub.sv
module bin_addsub
  import bcd_alu_pkg::*;
(
  input  word_t      a_i,
  input  word_t      b_i,
  input  logic       ci_i,
  output alu_flags_t add_o,
  output alu_flags_t sub_o
);
  assign add_o = bin_add(a_i, b_i, ci_i);
  assign sub_o = bin_sub(a_i, b_i, ci_i);

  always_comb begin
    // R1
    add_carry_sum_chk: assert ({add_o.c, add_o.res} == 9'(a_i) + 9'(b_i) + 9'(ci_i))
      else $error("binary add carry/sum mismatch");
    // R3
    sub_borrow_chk: assert (sub_o.c == (9'(a_i) >= 9'(b_i) + 9'(!ci_i)))
      else $error("binary subtract borrow mismatch");
  end
endmodule

// File: rtl/dec_adder.sv
module dec_adder
  import bcd_alu_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  logic  ci_i,
  output word_t res_o,
  output logic  n_o,
  output logic  v_o,
  output logic  c_o
);
  localparam int STEP_W = NIB_W + 2;

  // +6 correction on a digit sum above nine
  function automatic logic [STEP_W-1:0] digit_fix(logic [STEP_W-1:0] d);
    return (d > STEP_W'(9)) ? d + STEP_W'(6) : d;
  endfunction

  logic [STEP_W-1:0] lo_raw, lo_fix, hi_raw, hi_fix;
  logic              lo_carry;

  always_comb begin
    lo_raw   = STEP_W'(a_i[NIB_W-1:0]) + STEP_W'(b_i[NIB_W-1:0]) + STEP_W'(ci_i);
    lo_fix   = digit_fix(lo_raw);
    lo_carry = (lo_fix > STEP_W'(15));
    hi_raw   = STEP_W'(a_i[DATA_W-1:NIB_W]) + STEP_W'(b_i[DATA_W-1:NIB_W]) + STEP_W'(lo_carry);
    hi_fix   = digit_fix(hi_raw);
  end

  assign n_o   = hi_raw[NIB_W-1];
  assign v_o   = (hi_raw[NIB_W-1] ^ a_i[MSB]) & ~(a_i[MSB] ^ b_i[MSB]);
  assign c_o   = (hi_fix > STEP_W'(15));
  assign res_o = {hi_fix[NIB_W-1:0], lo_fix[NIB_W-1:0]};

  always_comb begin
    if (a_i[NIB_W-1:0] <= 4'd9 && b_i[NIB_W-1:0] <= 4'd9) begin
      // R5
      lo_digit_range_chk: assert (res_o[NIB_W-1:0] <= 4'd9)
        else $error("decimal add low digit out of range");
    end
  end
endmodule

// File: rtl/dec_subtractor.sv
module dec_subtractor
  import bcd_alu_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  logic  ci_i,
  output word_t res_o
);
  localparam int DIFF_W = NIB_W + 1;

  // -6 correction on a digit that borrowed
  function automatic logic [NIB_W-1:0] digit_unfix(logic [DIFF_W-1:0] d);
    return d[NIB_W] ? d[NIB_W-1:0] - NIB_W'(6) : d[NIB_W-1:0];
  endfunction

  logic [DIFF_W-1:0] lo_diff, hi_diff;
  logic              lo_borrow;

  always_comb begin
    lo_diff   = DIFF_W'(a_i[NIB_W-1:0]) - DIFF_W'(b_i[NIB_W-1:0]) - DIFF_W'(!ci_i);
    lo_borrow = lo_diff[NIB_W];
    hi_diff   = DIFF_W'(a_i[DATA_W-1:NIB_W]) - DIFF_W'(b_i[DATA_W-1:NIB_W]) - DIFF_W'(lo_borrow);
  end

  assign res_o = {digit_unfix(hi_diff), digit_unfix(lo_diff)};

  always_comb begin
    if (a_i[NIB_W-1:0] <= 4'd9 && b_i[NIB_W-1:0] <= 4'd9) begin
      // R9
      sub_lo_digit_chk: assert (res_o[NIB_W-1:0] <= 4'd9)
        else $error("decimal subtract low digit out of range");
    end
  end
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import bcd_alu_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       carry_i,
  input  logic       decimal_i,
  input  logic       sub_i,
  output logic [7:0] result_o,
  output logic       neg_o,
  output logic       ovf_o,
  output logic       zero_o,
  output logic       carry_o
);
  alu_flags_t bin_add_w, bin_sub_w;
  word_t      dadd_res, dsub_res;
  logic       dadd_n, dadd_v, dadd_c;

  bin_addsub u_bin (
    .a_i(acc_i), .b_i(opnd_i), .ci_i(carry_i),
    .add_o(bin_add_w), .sub_o(bin_sub_w)
  );

  dec_adder u_dadd (
    .a_i(acc_i), .b_i(opnd_i), .ci_i(carry_i),
    .res_o(dadd_res), .n_o(dadd_n), .v_o(dadd_v), .c_o(dadd_c)
  );

  dec_subtractor u_dsub (
    .a_i(acc_i), .b_i(opnd_i), .ci_i(carry_i),
    .res_o(dsub_res)
  );

  always_comb begin
    unique case ({decimal_i, sub_i})
      2'b00: begin
        result_o = bin_add_w.res; neg_o = bin_add_w.n; ovf_o = bin_add_w.v;
        zero_o = bin_add_w.z; carry_o = bin_add_w.c;
      end
      2'b01: begin
        result_o = bin_sub_w.res; neg_o = bin_sub_w.n; ovf_o = bin_sub_w.v;
        zero_o = bin_sub_w.z; carry_o = bin_sub_w.c;
      end
      2'b10: begin
        result_o = dadd_res; neg_o = dadd_n; ovf_o = dadd_v;
        zero_o = bin_add_w.z; carry_o = dadd_c;
      end
      default: begin
        result_o = dsub_res; neg_o = bin_sub_w.n; ovf_o = bin_sub_w.v;
        zero_o = bin_sub_w.z; carry_o = bin_sub_w.c;
      end
    endcase
  end

  logic bcd_in;
  assign bcd_in = is_bcd(acc_i) && is_bcd(opnd_i);

  always_comb begin
    if (decimal_i && !sub_i) begin
      // R6
      dec_add_zero_chk: assert (zero_o == (8'(acc_i + opnd_i + 8'(carry_i)) == 8'd0))
        else $error("decimal add zero flag mismatch");
    end
    if (decimal_i && sub_i) begin
      // R10
      dec_sub_zero_chk: assert (zero_o == (8'(acc_i - opnd_i - 8'(!carry_i)) == 8'd0))
        else $error("decimal subtract zero flag mismatch");
    end
    if (decimal_i && !sub_i && bcd_in) begin
      // R11
      dec_add_value_chk: assert (bcd_val(result_o) ==
          (bcd_val(acc_i) + bcd_val(opnd_i) + int'(carry_i)) % 100 &&
          carry_o == ((bcd_val(acc_i) + bcd_val(opnd_i) + int'(carry_i)) >= 100))
        else $error("decimal add value mismatch");
    end
    if (decimal_i && sub_i && bcd_in) begin
      // R12
      dec_sub_value_chk: assert (bcd_val(result_o) ==
          (bcd_val(acc_i) - bcd_val(opnd_i) - int'(!carry_i) + 100) % 100 &&
          carry_o == ((bcd_val(acc_i) - bcd_val(opnd_i) - int'(!carry_i)) >= 0))
        else $error("decimal subtract value mismatch");
    end
  end
endmodule

// File: tb/bcd_addsub_unit_test.sv
`timescale 1ns/100ps
module bcd_addsub_unit_test;
  logic       clk = 1'b0;
  logic [7:0] acc, opnd, result;
  logic       cin, dec, sub, neg, ovf, zero, cout;
  int         n_checks = 0;
  int         n_fail   = 0;
  int         cycles   = 0;
  bit         done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  bcd_addsub_unit uut (
    .acc_i(acc), .opnd_i(opnd), .carry_i(cin), .decimal_i(dec), .sub_i(sub),
    .result_o(result), .neg_o(neg), .ovf_o(ovf), .zero_o(zero), .carry_o(cout)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s a=%02h b=%02h c=%0d d=%0d s=%0d actual=%0h expected=%0h",
               tag, what, acc, opnd, cin, dec, sub, act, exp);
    end
  endtask

  function automatic int to_bcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  task automatic check_vector();
    int a, b, c, t, er, en, ev, ez, ec, lo, hi;
    a = int'(acc); b = int'(opnd); c = int'(cin);
    if (!dec && !sub) begin
      t = a + b + c; er = t & 255; ec = (t > 255);
      ev = (((a ^ b) & 128) == 0) && (((a ^ t) & 128) != 0);
      en = er >> 7; ez = (er == 0);
      chk("R1", "result", int'(result), er);
      chk("R1", "carry", int'(cout), ec);
      chk("R2", "ovf", int'(ovf), ev);
      chk("R2", "neg", int'(neg), en);
      chk("R2", "zero", int'(zero), ez);
    end else if (!dec && sub) begin
      t = a - b - (1 - c); er = t & 255; ec = (t >= 0);
      ev = (((a ^ b) & 128) != 0) && (((a ^ er) & 128) != 0);
      en = er >> 7; ez = (er == 0);
      chk("R3", "result", int'(result), er);
      chk("R3", "carry", int'(cout), ec);
      chk("R4", "ovf", int'(ovf), ev);
      chk("R4", "neg", int'(neg), en);
      chk("R4", "zero", int'(zero), ez);
    end else if (dec && !sub) begin
      lo = (a % 16) + (b % 16) + c;
      if (lo > 9) lo += 6;
      hi = a / 16 + b / 16 + ((lo > 15) ? 1 : 0);
      en = (hi >> 3) & 1;
      ev = ((((hi * 16) ^ a) & 128) != 0) && (((a ^ b) & 128) == 0);
      ez = (((a + b + c) & 255) == 0);
      if (hi > 9) hi += 6;
      ec = (hi > 15);
      er = (hi % 16) * 16 + (lo % 16);
      chk("R5", "low digit", int'(result[3:0]), er % 16);
      chk("R8", "high digit", int'(result[7:4]), er / 16);
      chk("R8", "carry", int'(cout), ec);
      chk("R7", "neg", int'(neg), en);
      chk("R7", "ovf", int'(ovf), ev);
      chk("R6", "zero", int'(zero), ez);
      if (a % 16 < 10 && a / 16 < 10 && b % 16 < 10 && b / 16 < 10) begin
        t = (a / 16) * 10 + a % 16 + (b / 16) * 10 + b % 16 + c;
        chk("R11", "bcd sum", int'(result), to_bcd(t % 100));
        chk("R11", "bcd carry", int'(cout), (t >= 100) ? 1 : 0);
      end
    end else begin
      t = a - b - (1 - c); er = t & 255;
      chk("R10", "carry", int'(cout), (t >= 0) ? 1 : 0);
      chk("R10", "ovf", int'(ovf), ((((a ^ b) & 128) != 0) && (((a ^ er) & 128) != 0)) ? 1 : 0);
      chk("R10", "neg", int'(neg), er >> 7);
      chk("R10", "zero", int'(zero), (er == 0) ? 1 : 0);
      lo = (a % 16) - (b % 16) - (1 - c);
      hi = a / 16 - b / 16;
      if (lo < 0) begin lo -= 6; hi -= 1; end
      if (hi < 0) hi -= 6;
      chk("R9", "result", int'(result), ((hi & 15) << 4) | (lo & 15));
      if (a % 16 < 10 && a / 16 < 10 && b % 16 < 10 && b / 16 < 10) begin
        t = (a / 16) * 10 + a % 16 - (b / 16) * 10 - b % 16 - (1 - c);
        chk("R12", "bcd diff", int'(result), to_bcd((t + 100) % 100));
        chk("R12", "bcd carry", int'(cout), (t >= 0) ? 1 : 0);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    acc = '0; opnd = '0; cin = 1'b0; dec = 1'b0; sub = 1'b0;
    #0.5;
    // R1 R2 idle inputs: 0 + 0 gives zero result, zero flag set
    chk("R1", "idle result", int'(result), 0);
    chk("R2", "idle zero", int'(zero), 1);
    for (int v = 0; v < (1 << 19); v++) begin
      #0.5;
      {sub, dec, cin, opnd, acc} = 19'(v);
      #0.5;
      check_vector();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule